// File: doc/BRIEF.md
# Vector Branch-Condition Loop Controller

This unit resolves one conditional branch over the elements of a vector, taking one element per clock. On every element it may step a count register down by one and test it against zero. It also tests the condition bit that belongs to that element. Both results are merged with the five-bit branch-options field. From the merged result the unit decides one of three outcomes: take the branch, leave the loop early, or cut the vector length short at the current element.

A start strobe copies every operand into the unit. These are the options field, one condition bit per element, the vector length, the starting count and the mode flags. The unit then works through the elements. When the loop ends it raises a one-cycle done pulse. At that point the taken flag, the final count, the resulting vector length and a length-changed flag are valid. They stay at those values until the next start is accepted.

The options field is numbered most-significant-bit first in the formulas, so its bit 0 is `bo_i[4]`. The roles by port bit are:
- `bo_i[4]`: ignore the condition bit.
- `bo_i[3]`: the condition sense.
- `bo_i[2]`: hold the count.
- `bo_i[1]`: the count sense.
- `bo_i[0]`: unused.

Top module: `vec_branch_loop`

## Requirements
- R1: While idle, a high `start_i` at a clock edge copies all operands, and element 0 is evaluated at the next edge, then one element per edge. While busy, `start_i` and every operand input are ignored, and `done_o` stays low.
- R2: Each element decrements the count by one, wrapping from 0 to all ones, unless `bo_i[2]` is 1. When `bo_i[2]` is 1 the count is unchanged.
- R3: The count result uses the count value after that element's decrement. When `mode64_i` is 1 it is nonzero if any of the 64 bits is set. When `mode64_i` is 0 only bits 31:0 are examined.
- R4: ctr_ok = `bo_i[2]` OR (count nonzero XOR `bo_i[1]`).
- R5: Element e tests `cr_bits_i[e]`: cond_ok = `bo_i[4]` OR NOT(`cr_bits_i[e]` XOR `bo_i[3]`). In R6 to R8, ok means cond_ok AND ctr_ok.
- R6: With `all_i` = 0, the loop stops at the first element where ok is 1 and `taken_o` = 1. If the last element is reached with ok = 0, the loop ends with `taken_o` = 0.
- R7: With `all_i` = 1, the loop stops at the first element where ok is 0 and `taken_o` = 0. If every element has ok = 1, the loop ends at the last element with `taken_o` = 1.
- R8: With `vlset_i` = 1, the first element e where ok equals `vsb_i` ends the loop with `taken_o` = ok and `vl_upd_o` = 1. `vl_o` is then e+1 if `vli_i` = 1, and e if `vli_i` = 0.
- R9: A start with `vl_i` = 0 raises `done_o` at the next edge. The count is unchanged, `taken_o` = 0 and `vl_upd_o` = 0.
- R10: `done_o` is a single-cycle pulse. If no truncation occurred, `vl_o` equals the copied length and `vl_upd_o` = 0. All result outputs hold until the next accepted start.
- R11: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a loop (taken only when idle) |
| bo_i | input | 5 | Branch-options field |
| cr_bits_i | input | 2**VL_W | Condition bit per element, bit e for element e |
| vl_i | input | VL_W | Vector length |
| ctr_i | input | CNT_W | Starting count |
| mode64_i | input | 1 | 1: full-width count test, 0: low 32 bits |
| all_i | input | 1 | Whole-vector branch mode |
| vlset_i | input | 1 | Truncate the length on a match |
| vsb_i | input | 1 | Value of ok that triggers truncation |
| vli_i | input | 1 | Include the matching element in the new length |
| done_o | output | 1 | One-cycle completion pulse |
| taken_o | output | 1 | Branch decision |
| ctr_o | output | CNT_W | Count register (the final count after done) |
| vl_o | output | VL_W | Resulting vector length |
| vl_upd_o | output | 1 | Length was truncated |

## Verification
The checker relies on one assumption about the inputs: a start that arrives in the same cycle as a done pulse may begin the next loop at once. For that reason the single-pulse property only applies when `start_i` is low. The step and hold properties are measured against the internal busy flag rather than against the inputs, so they stay valid when the operand inputs change during a run.

The bench deliberately keeps asserting `start_i`, with different operands, while a loop is busy. Back-to-back starts are always kept separate by idle cycles, so the start-during-done case never arises. Each run is compared against a behavioural model. The runs cover every options value with every combination of the mode flags, short lengths including zero, and counts near zero and across bit 32.

// File: rtl/vbl_pkg.sv
package vbl_pkg;
   localparam int BO_W         = 5;
   localparam int BO_CR_IGNORE = 4;  // MSB-first bit 0
   localparam int BO_CR_SENSE  = 3;  // MSB-first bit 1
   localparam int BO_CTR_HOLD  = 2;  // MSB-first bit 2
   localparam int BO_CTR_SENSE = 1;  // MSB-first bit 3

   typedef struct packed {
      logic [BO_W-1:0] bo;
      logic            mode64;
      logic            all;
      logic            vlset;
      logic            vsb;
      logic            vli;
   } vbl_cfg_t;
endpackage

// File: rtl/vbl_ctr_eval.sv
module vbl_ctr_eval #(
   parameter int CNT_W = 64,
   parameter int LOW_W = 32
) (
   input  logic [CNT_W-1:0] ctr,
   input  logic             hold,
   input  logic             sense,
   input  logic             mode64,
   output logic [CNT_W-1:0] ctr_nxt,
   output logic             ctr_ok
);
   logic nz;

   assign ctr_nxt = hold ? ctr : ctr - CNT_W'(1);

   generate
      if (CNT_W > LOW_W) begin : g_split
         logic lo_nz, hi_nz;
         assign lo_nz = |ctr_nxt[LOW_W-1:0];
         assign hi_nz = |ctr_nxt[CNT_W-1:LOW_W];
         assign nz    = lo_nz | (mode64 & hi_nz);
      end else begin : g_flat
         logic unused_mode;
         assign unused_mode = mode64;
         assign nz          = |ctr_nxt;
      end
   endgenerate

   assign ctr_ok = hold | (nz ^ sense);
endmodule

// File: rtl/vbl_cond_eval.sv
module vbl_cond_eval #(
   parameter int IDX_W = 7,
   localparam int NUM_EL = 1 << IDX_W
) (
   input  logic [NUM_EL-1:0] cr_bits,
   input  logic [IDX_W-1:0]  idx,
   input  logic              ignore,
   input  logic              sense,
   output logic              cond_ok
);
   logic sel_bit;

   assign sel_bit = cr_bits[idx];
   assign cond_ok = ignore | ~(sel_bit ^ sense);
endmodule

// File: rtl/vbl_exit_dec.sv
module vbl_exit_dec #(
   parameter int VL_W = 7
) (
   input  logic [VL_W-1:0] idx,
   input  logic [VL_W-1:0] vl,
   input  logic            ok,
   input  logic            all,
   input  logic            vlset,
   input  logic            vsb,
   input  logic            vli,
   output logic            fin,
   output logic            trunc,
   output logic [VL_W-1:0] new_vl
);
   logic last, early;

   assign last   = (idx == vl - VL_W'(1));
   assign early  = all ? ~ok : ok;
   assign trunc  = vlset & (ok == vsb);
   assign fin    = last | early | trunc;
   assign new_vl = vli ? idx + VL_W'(1) : idx;
endmodule

// File: rtl/vec_branch_loop.sv
module vec_branch_loop #(
   parameter int CNT_W = 64,
   parameter int VL_W  = 7,
   localparam int NUM_EL = 1 << VL_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [4:0]          bo_i,
   input  logic [NUM_EL-1:0]   cr_bits_i,
   input  logic [VL_W-1:0]     vl_i,
   input  logic [CNT_W-1:0]    ctr_i,
   input  logic                mode64_i,
   input  logic                all_i,
   input  logic                vlset_i,
   input  logic                vsb_i,
   input  logic                vli_i,
   output logic                done_o,
   output logic                taken_o,
   output logic [CNT_W-1:0]    ctr_o,
   output logic [VL_W-1:0]     vl_o,
   output logic                vl_upd_o
);
   import vbl_pkg::*;

   generate
      if (CNT_W <= 32) begin : g_bad_cnt
         $error("vec_branch_loop: CNT_W must exceed 32");
      end
      if (VL_W < 1 || VL_W > 12) begin : g_bad_vl
         $error("vec_branch_loop: VL_W out of range");
      end
   endgenerate

   vbl_cfg_t            cfg_q;
   logic                busy_q, done_q, taken_q, upd_q;
   logic [VL_W-1:0]     idx_q, vl_q, vlo_q;
   logic [NUM_EL-1:0]   cr_q;
   logic [CNT_W-1:0]    ctr_q, ctr_nxt;
   logic                ctr_ok, cond_ok, ok, fin, trunc;
   logic [VL_W-1:0]     new_vl;

   vbl_ctr_eval #(.CNT_W(CNT_W), .LOW_W(32)) u_ctr (
      .ctr     (ctr_q),
      .hold    (cfg_q.bo[BO_CTR_HOLD]),
      .sense   (cfg_q.bo[BO_CTR_SENSE]),
      .mode64  (cfg_q.mode64),
      .ctr_nxt (ctr_nxt),
      .ctr_ok  (ctr_ok)
   );

   vbl_cond_eval #(.IDX_W(VL_W)) u_cond (
      .cr_bits (cr_q),
      .idx     (idx_q),
      .ignore  (cfg_q.bo[BO_CR_IGNORE]),
      .sense   (cfg_q.bo[BO_CR_SENSE]),
      .cond_ok (cond_ok)
   );

   assign ok = cond_ok & ctr_ok;

   vbl_exit_dec #(.VL_W(VL_W)) u_exit (
      .idx    (idx_q),
      .vl     (vl_q),
      .ok     (ok),
      .all    (cfg_q.all),
      .vlset  (cfg_q.vlset),
      .vsb    (cfg_q.vsb),
      .vli    (cfg_q.vli),
      .fin    (fin),
      .trunc  (trunc),
      .new_vl (new_vl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q   <= '0;
         cr_q    <= '0;
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         taken_q <= 1'b0;
         upd_q   <= 1'b0;
         idx_q   <= '0;
         vl_q    <= '0;
         vlo_q   <= '0;
         ctr_q   <= '0;
      end else begin
         done_q <= 1'b0;
         if (busy_q) begin
            ctr_q <= ctr_nxt;
            idx_q <= idx_q + VL_W'(1);
            if (fin) begin
               busy_q  <= 1'b0;
               done_q  <= 1'b1;
               taken_q <= ok;
               if (trunc) begin
                  vlo_q <= new_vl;
                  upd_q <= 1'b1;
               end
            end
         end else if (start_i) begin
            cfg_q   <= '{bo: bo_i, mode64: mode64_i, all: all_i,
                         vlset: vlset_i, vsb: vsb_i, vli: vli_i};
            cr_q    <= cr_bits_i;
            vl_q    <= vl_i;
            vlo_q   <= vl_i;
            ctr_q   <= ctr_i;
            idx_q   <= '0;
            taken_q <= 1'b0;
            upd_q   <= 1'b0;
            if (vl_i == '0) done_q <= 1'b1;
            else            busy_q <= 1'b1;
         end
      end
   end

   assign done_o   = done_q;
   assign taken_o  = taken_q;
   assign ctr_o    = ctr_q;
   assign vl_o     = vlo_q;
   assign vl_upd_o = upd_q;
endmodule

// File: rtl/vbl_checker.sv
module vbl_checker #(
   parameter int CNT_W = 64,
   parameter int VL_W  = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [VL_W-1:0]  vl_i,
   input logic [CNT_W-1:0] ctr_i,
   input logic             busy,
   input logic             hold,
   input logic [VL_W-1:0]  vl_lat,
   input logic             done_o,
   input logic             taken_o,
   input logic [CNT_W-1:0] ctr_o,
   input logic [VL_W-1:0]  vl_o,
   input logic             vl_upd_o
);
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && !start_i |=> !done_o); // R10
   AST_BUSY_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !done_o); // R1
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !start_i |=> $stable(ctr_o) && $stable(taken_o) && $stable(vl_o) && $stable(vl_upd_o)); // R10
   AST_VL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && start_i && vl_i == '0 |=> done_o && !taken_o && !vl_upd_o && ctr_o == $past(ctr_i)); // R9
   AST_CTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !hold |=> ctr_o == $past(ctr_o) - CNT_W'(1)); // R2
   AST_CTR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      busy && hold |=> $stable(ctr_o)); // R2
   AST_TRUNC_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      vl_upd_o |-> vl_o <= vl_lat); // R8
endmodule

bind vec_branch_loop vbl_checker #(.CNT_W(CNT_W), .VL_W(VL_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_i  (start_i),
   .vl_i     (vl_i),
   .ctr_i    (ctr_i),
   .busy     (busy_q),
   .hold     (cfg_q.bo[vbl_pkg::BO_CTR_HOLD]),
   .vl_lat   (vl_q),
   .done_o   (done_o),
   .taken_o  (taken_o),
   .ctr_o    (ctr_o),
   .vl_o     (vl_o),
   .vl_upd_o (vl_upd_o)
);

// File: tb/vec_branch_loop_tb.sv
`timescale 1ns/1ps
module vec_branch_loop_tb;
   localparam int CNT_W = 64;
   localparam int VL_W  = 7;
   localparam int NEL   = 1 << VL_W;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic [4:0]       bo_i = '0;
   logic [NEL-1:0]   cr_bits_i = '0;
   logic [VL_W-1:0]  vl_i = '0;
   logic [CNT_W-1:0] ctr_i = '0;
   logic             mode64_i = 1'b0, all_i = 1'b0, vlset_i = 1'b0, vsb_i = 1'b0, vli_i = 1'b0;
   logic             done_o, taken_o, vl_upd_o;
   logic [CNT_W-1:0] ctr_o;
   logic [VL_W-1:0]  vl_o;

   int compared = 0;
   int mismatched = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   vec_branch_loop #(.CNT_W(CNT_W), .VL_W(VL_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .bo_i(bo_i), .cr_bits_i(cr_bits_i),
      .vl_i(vl_i), .ctr_i(ctr_i), .mode64_i(mode64_i), .all_i(all_i), .vlset_i(vlset_i),
      .vsb_i(vsb_i), .vli_i(vli_i), .done_o(done_o), .taken_o(taken_o), .ctr_o(ctr_o),
      .vl_o(vl_o), .vl_upd_o(vl_upd_o)
   );

   task automatic chk(input bit good, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      compared++;
      if (!good) begin
         mismatched++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Behavioural model: walks the elements, returns edges after the start edge until done
   task automatic model(input logic [4:0] bo, input logic [NEL-1:0] cr, input int vl,
                        input logic [63:0] c0, input bit m64, input bit all, input bit vlset,
                        input bit vsb, input bit vli, output int nedge, output bit tk,
                        output logic [63:0] c, output int nvl, output bit upd);
      c = c0; tk = 0; nvl = vl; upd = 0; nedge = 0;
      for (int e = 0; e < vl; e++) begin
         bit cok, tok, ok, stop;
         logic [63:0] seen;
         if (!bo[2]) c = c - 64'd1;
         seen = m64 ? c : {32'd0, c[31:0]};
         tok  = bo[2] | ((seen != 0) ^ bo[1]);
         cok  = bo[4] | !(cr[e] ^ bo[3]);
         ok   = cok & tok;
         stop = (e == vl - 1) || (all ? !ok : ok);
         if (vlset && (ok == vsb)) begin
            stop = 1; upd = 1; nvl = vli ? e + 1 : e;
         end
         if (stop) begin
            tk = ok; nedge = e + 1;
            return;
         end
      end
   endtask

   task automatic run(input string req, input logic [4:0] bo, input logic [NEL-1:0] cr,
                      input int vl, input logic [63:0] c0, input bit m64, input bit all,
                      input bit vlset, input bit vsb, input bit vli, input bit poke);
      int nedge, nvl;
      bit tk, upd;
      logic [63:0] c;
      model(bo, cr, vl, c0, m64, all, vlset, vsb, vli, nedge, tk, c, nvl, upd);
      @(negedge clk);
      bo_i = bo; cr_bits_i = cr; vl_i = VL_W'(vl); ctr_i = c0;
      mode64_i = m64; all_i = all; vlset_i = vlset; vsb_i = vsb; vli_i = vli;
      start_i = 1'b1;
      @(posedge clk);
      for (int k = 0; k <= nedge; k++) begin
         @(negedge clk);
         if (poke && nedge > 0 && k == 0) begin
            // R1: start and operands changed while busy must be ignored
            ctr_i = ~c0; vl_i = VL_W'(5); bo_i = ~bo; cr_bits_i = ~cr;
         end else begin
            start_i = 1'b0;
         end
         chk(done_o == (k == nedge), "R10", "done_o", 64'(done_o), 64'(k == nedge));
         if (k == nedge) begin
            chk(taken_o == tk, req, "taken_o", 64'(taken_o), 64'(tk));
            chk(ctr_o == c, req, "ctr_o", ctr_o, c);
            chk(vl_o == VL_W'(nvl), req, "vl_o", 64'(vl_o), 64'(nvl));
            chk(vl_upd_o == upd, req, "vl_upd_o", 64'(vl_upd_o), 64'(upd));
         end
      end
      start_i = 1'b0;
      for (int k = 0; k < 2; k++) begin
         @(negedge clk);
         chk(done_o == 1'b0, "R10", "done_o idle", 64'(done_o), 64'd0);
         chk(taken_o == tk && ctr_o == c && vl_o == VL_W'(nvl) && vl_upd_o == upd,
             "R10", "held ctr_o", ctr_o, c);
      end
   endtask

   initial begin
      #(20 * 200000);
      if (!finished) begin
         mismatched++;
         compared++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      chk(done_o == 0 && taken_o == 0 && vl_upd_o == 0, "R11", "flags", {61'd0, done_o, taken_o, vl_upd_o}, 64'd0);
      chk(ctr_o == 0 && vl_o == 0, "R11", "ctr_o/vl_o", ctr_o | 64'(vl_o), 64'd0);
      rst_n = 1'b1;

      // R7: whole-vector mode, count only, length 2
      run("R7", 5'b10000, '0, 2, 64'd1, 1, 1, 0, 0, 0, 0);
      run("R7", 5'b10000, '0, 2, 64'd2, 1, 1, 0, 0, 0, 0);
      run("R7", 5'b10000, '0, 2, 64'd3, 1, 1, 0, 0, 0, 0);
      // R9: empty vector
      run("R9", 5'b10000, '0, 0, 64'd7, 1, 0, 0, 0, 0, 0);
      // R6: first condition match at element 3, condition sense 1
      run("R6", 5'b01100, NEL'(8'b0000_1000), 6, 64'd9, 1, 0, 0, 0, 0, 0);
      run("R6", 5'b01100, '0, 5, 64'd9, 1, 0, 0, 0, 0, 0);
      // R5: condition sense 0, bits set until element 2
      run("R5", 5'b00100, NEL'(8'b0000_0011), 6, 64'd4, 1, 0, 0, 0, 0, 0);
      // R2: hold bit keeps the count
      run("R2", 5'b10100, '0, 4, 64'd5, 1, 1, 0, 0, 0, 1);
      // R3: 32-bit view of 0x1_0000_0001 hits zero after one decrement
      run("R3", 5'b10000, '0, 3, 64'h1_0000_0001, 0, 1, 0, 0, 0, 0);
      run("R3", 5'b10000, '0, 3, 64'h1_0000_0001, 1, 1, 0, 0, 0, 0);
      // R4: count sense inverted, wrap from zero
      run("R4", 5'b10010, '0, 3, 64'd0, 1, 0, 0, 0, 0, 0);
      run("R4", 5'b10010, '0, 4, 64'd3, 1, 0, 0, 0, 0, 1);
      // R8: truncation with and without the inclusive bit
      run("R8", 5'b00100, NEL'(8'b0000_0111), 7, 64'd1, 1, 1, 1, 0, 1, 0);
      run("R8", 5'b00100, NEL'(8'b0000_0111), 7, 64'd1, 1, 1, 1, 0, 0, 0);
      run("R8", 5'b10000, '0, 6, 64'd3, 1, 0, 1, 0, 1, 1);
      // R1: start held during a long run
      run("R1", 5'b10000, '0, 9, 64'd100, 1, 1, 0, 0, 0, 1);

      // Sweep: every options value against every flag combination
      for (int b = 0; b < 32; b++) begin
         for (int f = 0; f < 32; f++) begin
            logic [NEL-1:0] cr;
            logic [63:0] c0;
            int vl, pick;
            cr = {$urandom, $urandom, $urandom, $urandom};
            vl = $urandom_range(0, 9);
            pick = $urandom_range(0, 7);
            c0 = (pick == 7) ? 64'h1_0000_0002 : (pick == 6) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'(pick);
            run("R4", 5'(b), cr, vl, c0, f[0], f[1], f[2], f[3], f[4], (f % 5) == 0);
         end
      end

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule